// File: doc/BRIEF.md
# PWM Fault Guard

This block sits between a motor-control PWM generator and the power stage. It watches two external fault inputs. A rising level on either input latches a sticky event flag for that input. While a flag is set, the block forces a programmable group of PWM outputs to their idle level, and can raise a maskable interrupt line for that input.

Software uses a small byte-wide register port. A read-only status register shows both flags together with the synchronised level of each fault pin. Flags are cleared by writing ones to an acknowledge register. An enable register gates the interrupt lines. Two mapping registers, one per fault input, choose which PWM outputs each fault shuts off. Output protection works whatever the interrupt enables hold.

Top module: `pwm_fault_guard`

## Requirements
- R1: After the first clock edge that samples a fault input high following a low period, that input's flag reads 1 no later than two clock cycles later. The pin-level bit reads 1 one cycle after that sampling edge.
- R2: Writing to address 1 with bit 0 (fault 0) or bit 1 (fault 1) set to 1 clears the matching flag. A 0 in a bit leaves that flag unchanged. A flag stays set after its pin returns low until it is acknowledged.
- R3: Writes to the status register (address 0) change no flag and no other state.
- R4: Interrupt enable register at address 2: bit 0 enables irq[0] and bit 1 enables irq[1]. irq[k] is 1 exactly when flag k is set and enable bit k is 1.
- R5: While flag k is set, every PWM output whose bit is 1 in the mapping register of fault k (address 3 for fault 0, address 4 for fault 1) is held at the idle level (0 by default), whatever the enables hold. Every other output passes pwm_in through.
- R6: Status register layout at address 0: bit 7 is the level of pin 1, bit 6 is flag 1, bits 5 to 2 read 0, bit 1 is the level of pin 0, bit 0 is flag 0.
- R7: Reset clears both flags, the enables and the mappings. The pin-level bits are not forced by reset: they follow the pin during and after reset. A pin that is already high when reset is released does not set its flag.
- R8: If a new rising edge and an acknowledge of the same flag land in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_in | input | 2 | Asynchronous fault inputs, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational on reg_addr |
| pwm_in | input | PWM_W | PWM outputs from the generator |
| pwm_out | output | PWM_W | PWM outputs after fault gating |
| irq | output | 2 | Per-fault interrupt requests |

## Verification
A flag that is stuck or lost shows up at once as a wrong pwm_out: mapped bits pass through when they should be idle, or stay idle after an acknowledge. The same flag also shows as a wrong irq level in the same cycle. A flag that is set late appears as a missing status bit at the third sampled edge. Errors in the sync chain show in the status pin bits one cycle after the pin is sampled. A wrong set-versus-acknowledge priority is only visible in the cycle of the collision, so the bench builds that exact cycle.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;

   localparam int NFLT = 2;

   typedef enum logic [2:0] {
      RA_STAT = 3'd0,
      RA_ACK  = 3'd1,
      RA_IEN  = 3'd2,
      RA_MAP0 = 3'd3,
      RA_MAP1 = 3'd4
   } reg_addr_e;

   function automatic logic [7:0] pack_status(input logic [NFLT-1:0] lvl,
                                              input logic [NFLT-1:0] flg);
      return {lvl[1], flg[1], 4'b0000, lvl[0], flg[0]};
   endfunction

endpackage

// File: rtl/pwm_fault_chan.sv
module pwm_fault_chan #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic ack_i,
   input  logic ien_i,
   output logic level_o,
   output logic flag_o,
   output logic irq_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pwm_fault_chan: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   rise;

   // Sync chain is deliberately unreset: the level bit follows the pin in reset
   always_ff @(posedge clk) begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= sync_q[SYNC_STAGES-1];
   end

   assign level_o = sync_q[SYNC_STAGES-1];
   assign rise    = sync_q[SYNC_STAGES-1] & ~prev_q;

   // Set has priority over acknowledge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (rise)  flag_o <= 1'b1;
      else if (ack_i) flag_o <= 1'b0;
   end

   assign irq_o = flag_o & ien_i;

   AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> flag_o);                                           // R1
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !rise) |=> !flag_o);                               // R2
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !ack_i) |=> flag_o);                              // R2
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && ack_i) |=> flag_o);                                 // R8

endmodule

// File: rtl/pwm_fault_regs.sv
module pwm_fault_regs
   import pwm_fault_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 8,
   parameter int PWM_W  = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_i,
   input  logic [ADDR_W-1:0]          addr_i,
   input  logic [DATA_W-1:0]          wdata_i,
   input  logic [NFLT-1:0]            level_i,
   input  logic [NFLT-1:0]            flag_i,
   output logic [DATA_W-1:0]          rdata_o,
   output logic [NFLT-1:0]            ack_o,
   output logic [NFLT-1:0]            ien_o,
   output logic [NFLT-1:0][PWM_W-1:0] map_o
);

   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(RA_STAT);
   localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(RA_ACK);
   localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(RA_IEN);
   localparam logic [ADDR_W-1:0] A_MAP0 = ADDR_W'(RA_MAP0);

   logic sel_ack, sel_ien;
   logic [NFLT-1:0] sel_map;

   assign sel_ack = wr_i && (addr_i == A_ACK);
   assign sel_ien = wr_i && (addr_i == A_IEN);

   // Acknowledge is a single-cycle pulse; nothing is stored
   assign ack_o = sel_ack ? wdata_i[NFLT-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ien_o <= '0;
      else if (sel_ien) ien_o <= wdata_i[NFLT-1:0];
   end

   generate
      for (genvar k = 0; k < NFLT; k++) begin : g_map
         assign sel_map[k] = wr_i && (addr_i == A_MAP0 + ADDR_W'(k));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          map_o[k] <= '0;
            else if (sel_map[k]) map_o[k] <= wdata_i[PWM_W-1:0];
         end
      end
   endgenerate

   always_comb begin
      rdata_o = '0;
      if (addr_i == A_STAT)      rdata_o[7:0] = pack_status(level_i, flag_i);
      else if (addr_i == A_IEN)  rdata_o[NFLT-1:0] = ien_o;
      else begin
         for (int k = 0; k < NFLT; k++)
            if (addr_i == A_MAP0 + ADDR_W'(k)) rdata_o[PWM_W-1:0] = map_o[k];
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^wdata_i;

   AST_STAT_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == A_STAT) |=> ($stable(ien_o) && $stable(map_o)));  // R3
   AST_STAT_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == A_STAT) |-> (ack_o == '0));                   // R3

endmodule

// File: rtl/pwm_fault_gate.sv
module pwm_fault_gate
   import pwm_fault_pkg::*;
#(
   parameter int PWM_W    = 6,
   parameter bit PWM_IDLE = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [PWM_W-1:0]           pwm_i,
   input  logic [NFLT-1:0]            flag_i,
   input  logic [NFLT-1:0][PWM_W-1:0] map_i,
   output logic [PWM_W-1:0]           pwm_o
);

   logic [PWM_W-1:0] kill;

   generate
      for (genvar b = 0; b < PWM_W; b++) begin : g_bit
         logic [NFLT-1:0] col;
         for (genvar k = 0; k < NFLT; k++) begin : g_col
            assign col[k] = map_i[k][b];
         end
         assign kill[b] = |(col & flag_i);

         if (PWM_IDLE) begin : g_idle_hi
            assign pwm_o[b] = pwm_i[b] | kill[b];
         end else begin : g_idle_lo
            assign pwm_o[b] = pwm_i[b] & ~kill[b];
         end

         AST_FORCED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            ((flag_i[0] && map_i[0][b]) || (flag_i[1] && map_i[1][b]))
               |-> (pwm_o[b] == PWM_IDLE));                            // R5
         AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_i == '0) |-> (pwm_o[b] == pwm_i[b]));                // R5
      end
   endgenerate

endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
   import pwm_fault_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter int DATA_W      = 8,
   parameter int PWM_W       = 6,
   parameter int SYNC_STAGES = 2,
   parameter bit PWM_IDLE    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NFLT-1:0]   fault_in,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [PWM_W-1:0]  pwm_in,
   output logic [PWM_W-1:0]  pwm_out,
   output logic [NFLT-1:0]   irq
);

   generate
      if (DATA_W < 8)                    begin : g_bad_data
         $error("pwm_fault_guard: DATA_W must hold the 8-bit status layout");
      end
      if (PWM_W < 1 || PWM_W > DATA_W)   begin : g_bad_pwm
         $error("pwm_fault_guard: PWM_W must be 1..DATA_W");
      end
      if (ADDR_W < 3)                    begin : g_bad_addr
         $error("pwm_fault_guard: ADDR_W must be at least 3");
      end
   endgenerate

   logic [NFLT-1:0]            level, flag, ack, ien;
   logic [NFLT-1:0][PWM_W-1:0] fmap;

   pwm_fault_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PWM_W(PWM_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
      .wdata_i(reg_wdata), .level_i(level), .flag_i(flag),
      .rdata_o(reg_rdata), .ack_o(ack), .ien_o(ien), .map_o(fmap)
   );

   generate
      for (genvar k = 0; k < NFLT; k++) begin : g_chan
         pwm_fault_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
            .clk(clk), .rst_n(rst_n), .pin_i(fault_in[k]), .ack_i(ack[k]),
            .ien_i(ien[k]), .level_o(level[k]), .flag_o(flag[k]),
            .irq_o(irq[k])
         );

         AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            !ien[k] |-> !irq[k]);                                     // R4
         AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            irq[k] |-> flag[k]);                                      // R4
      end
   endgenerate

   pwm_fault_gate #(.PWM_W(PWM_W), .PWM_IDLE(PWM_IDLE)) u_gate (
      .clk(clk), .rst_n(rst_n), .pwm_i(pwm_in), .flag_i(flag),
      .map_i(fmap), .pwm_o(pwm_out)
   );

endmodule

// File: tb/pwm_fault_guard_tb.sv
module pwm_fault_guard_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] fault_in = 2'b00;
   logic       reg_wr = 1'b0;
   logic [2:0] reg_addr = 3'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic [5:0] pwm_in = 6'h00;
   logic [5:0] pwm_out;
   logic [1:0] irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   pwm_fault_guard u_dut (
      .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pwm_in(pwm_in), .pwm_out(pwm_out), .irq(irq)
   );

   // {pwm_in, map0, map1, ien, faults, expected pwm_out, expected irq}
   typedef struct packed {
      logic [5:0] pin; logic [5:0] m0; logic [5:0] m1;
      logic [1:0] en;  logic [1:0] flt; logic [5:0] xout; logic [1:0] xirq;
   } vec_t;
   localparam vec_t VECS [4] = '{
      '{6'h3F, 6'h0F, 6'h30, 2'b11, 2'b01, 6'h30, 2'b01},
      '{6'h3F, 6'h0F, 6'h30, 2'b00, 2'b10, 6'h0F, 2'b00},
      '{6'h2A, 6'h03, 6'h06, 2'b10, 2'b11, 6'h28, 2'b10},
      '{6'h15, 6'h00, 6'h00, 2'b11, 2'b11, 6'h15, 2'b11}
   };

   function automatic logic [7:0] stat(input logic [1:0] lvl, input logic [1:0] flg);
      return {lvl[1], flg[1], 4'b0000, lvl[0], flg[0]};
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = 3'd0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      logic [7:0] d;
      // ---- R7: reset state, level bit live during reset
      fault_in = 2'b10; pwm_in = 6'h2A;
      repeat (4) @(negedge clk);
      rd(3'd0, d); chk("R7 status in reset", d, 8'h80);
      chk("R7 irq in reset", {6'b0, irq}, 8'h00);
      chk("R7 pwm passes in reset", {2'b0, pwm_out}, 8'h2A);
      rd(3'd2, d); chk("R7 enable reset", d, 8'h00);
      rd(3'd3, d); chk("R7 map0 reset", d, 8'h00);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      rd(3'd0, d); chk("R7 held pin sets no flag", d, 8'h80);
      fault_in = 2'b00;
      repeat (4) @(negedge clk);
      rd(3'd0, d); chk("R6 idle status", d, 8'h00);

      // ---- vector table: R4 R5 R6 R2
      foreach (VECS[i]) begin
         wr(3'd3, {2'b0, VECS[i].m0});
         wr(3'd4, {2'b0, VECS[i].m1});
         wr(3'd2, {6'b0, VECS[i].en});
         pwm_in = VECS[i].pin;
         @(negedge clk); fault_in = VECS[i].flt;
         repeat (4) @(negedge clk);
         rd(3'd0, d); chk("R6 status with pins high", d, stat(VECS[i].flt, VECS[i].flt));
         chk("R5 gated pwm", {2'b0, pwm_out}, {2'b0, VECS[i].xout});
         chk("R4 irq", {6'b0, irq}, {6'b0, VECS[i].xirq});
         fault_in = 2'b00;
         repeat (4) @(negedge clk);
         rd(3'd0, d); chk("R2 flag sticky after pin low", d, stat(2'b00, VECS[i].flt));
         chk("R5 still gated after pin low", {2'b0, pwm_out}, {2'b0, VECS[i].xout});
         wr(3'd1, 8'h03);
         rd(3'd0, d); chk("R2 ack clears", d, 8'h00);
         chk("R5 pass after ack", {2'b0, pwm_out}, {2'b0, VECS[i].pin});
         chk("R4 irq low after ack", {6'b0, irq}, 8'h00);
      end

      // ---- R1: latency from sampling edge
      wr(3'd3, 8'h01); wr(3'd2, 8'h01); pwm_in = 6'h3F;
      @(negedge clk); fault_in = 2'b01;
      @(negedge clk);            // after sampling edge
      @(negedge clk);            // one cycle later
      rd(3'd0, d); chk("R1 level after one cycle", d, 8'h02);
      @(negedge clk);            // two cycles later
      rd(3'd0, d); chk("R1 flag within two cycles", d, 8'h03);
      chk("R1 irq with flag", {6'b0, irq}, 8'h01);
      fault_in = 2'b00;
      repeat (4) @(negedge clk);

      // ---- R3: status write does nothing
      wr(3'd0, 8'hFF);
      rd(3'd0, d); chk("R3 status write keeps flag", d, 8'h01);
      rd(3'd2, d); chk("R3 status write keeps enable", d, 8'h01);

      // ---- R2: zero bit leaves flag
      wr(3'd1, 8'h02);
      rd(3'd0, d); chk("R2 ack of other bit", d, 8'h01);
      chk("R5 mapped bit idle", {2'b0, pwm_out}, 8'h3E);

      // ---- R8: rise and ack in the same cycle
      @(negedge clk); fault_in = 2'b01;
      @(negedge clk);                    // sampling edge passed
      @(negedge clk);                    // rise active until next edge
      reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h01;
      @(negedge clk);
      reg_wr = 1'b0;
      rd(3'd0, d); chk("R8 set wins over ack", d, 8'h03);
      wr(3'd1, 8'h01);
      rd(3'd0, d); chk("R2 ack with pin high clears", d, 8'h02);
      chk("R4 irq clears", {6'b0, irq}, 8'h00);

      done = 1'b1;
      finish_run();
   end

endmodule